// File: doc/BRIEF.md
# Sector Transfer Sequencer

This block carries out the four sector-transfer commands of a floppy disk controller: single and multiple sector read, single and multiple sector write. A host writes a command byte, and the block walks through an optional head-settle pause, a head-load pause and a write-protect test. It then asks a drive model for the sector named in the sector register. When the drive signals that the sector is under the head, the block compares the track number recorded on disk with its own track register. If they agree, the block moves the sector bytes one at a time through the data register. A data-request line paces the host.

Delays are measured in milliseconds of a prescaled clock: `CYC_PER_MS` clock cycles make one millisecond. The data-request line honours a minimum spacing of `DRQ_GAP` cycles after each change. The drive side is a plain buffer port: the block drives a byte address, reads bytes combinationally and emits a write strobe. The drive reports the on-disk track together with a one-cycle arrival strobe.

Top module: `sector_xfer_seq`

## Requirements
- R1: After reset `busy`, `drq`, `irq`, `err_rnf` and `err_wprot` are low, the track register (address 1) reads 0 and the sector register (address 2) reads 1.
- R2: A write to address 0 whose bits 7:6 are `10` starts a command: `busy` is high after that edge and `irq`, `err_rnf`, `err_wprot` are low. Any other command code clears `irq` and leaves `busy` low.
- R3: If `drv_ready` is low when a command is accepted, `busy` stays low and `irq` is high after that same edge.
- R4: `sec_req` is high in the cycle that follows LOAD_MS·CYC_PER_MS edges after the accepting edge. When command bit 2 is set, it follows (SETTLE_MS+LOAD_MS)·CYC_PER_MS edges.
- R5: For a write command (bits 7:5 = `101`) with `drv_wprot` high at the end of the load pause, `err_wprot` and `irq` rise and `busy` falls on the edge where `sec_req` would otherwise have risen, and no `sec_req` is issued. Read commands ignore `drv_wprot`.
- R6: `sec_req` is a one-cycle pulse, and `sec_num` carries the sector register while it is high.
- R7: A `sec_arrive` strobe with `disk_track` unequal to the track register sets `err_rnf` and `irq`, clears `busy` and leaves `drq` low.
- R8: For a write, `drq` is high right after the edge that samples a matching `sec_arrive`. Each data-register write (address 3) emits `buf_we` with that byte, with `buf_addr` stepping 0 to SECTOR_BYTES-1 in order.
- R9: For a read, each data-register read returns `buf_rdata` for a `buf_addr` that steps 0 to SECTOR_BYTES-1 in order.
- R10: A data-register access lowers `drq` on its edge. `drq` rises again exactly DRQ_GAP edges later, and never while `busy` is low.
- R11: On the edge of the last byte of a single-sector read or write, or of a multi-sector write, `busy` and `drq` fall and `irq` rises.
- R12: For a multi-sector read (bit 4 set), the last byte increments the sector register and issues a new `sec_req` carrying the new number, with `busy` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 2 | 0 command, 1 track, 2 sector, 3 data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| drv_ready | input | 1 | Drive ready |
| drv_wprot | input | 1 | Medium is write protected |
| sec_req | output | 1 | Request for the sector in `sec_num` |
| sec_num | output | 8 | Requested sector number |
| sec_arrive | input | 1 | Requested sector is under the head |
| disk_track | input | 8 | Track number recorded on disk, valid with `sec_arrive` |
| buf_addr | output | clog2(SECTOR_BYTES) | Byte index in the sector buffer |
| buf_we | output | 1 | Sector buffer write strobe |
| buf_wdata | output | 8 | Byte to store |
| buf_rdata | input | 8 | Byte at `buf_addr` |
| busy | output | 1 | Command in progress |
| drq | output | 1 | Data register wants service |
| irq | output | 1 | Command completed |
| err_rnf | output | 1 | Recorded track did not match |
| err_wprot | output | 1 | Write refused on protected medium |

## Verification
A wrong phase counter or prescaler shows up as `sec_req` arriving early or late against a cycle count fixed when the command is accepted. A stale byte index appears at once as a wrong byte on `reg_rdata` or a wrong `buf_addr` under `buf_we`, and it leaves the sector length off by the end of the sector. A pacing fault changes the measured distance from an access to the next `drq` rise within about DRQ_GAP cycles. A wrong end decision appears on `busy`/`irq` at the last byte, or as a missing or misnumbered follow-on `sec_req`.

// File: rtl/sxs_pkg.sv
package sxs_pkg;

  localparam int SXS_DW = 8;

  localparam logic [1:0] ADR_CMD = 2'd0;
  localparam logic [1:0] ADR_TRK = 2'd1;
  localparam logic [1:0] ADR_SEC = 2'd2;
  localparam logic [1:0] ADR_DAT = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOAD,
    ST_FIND,
    ST_XFER
  } sxs_state_t;

  // bits 7:6 of a command byte select the sector-transfer group
  function automatic logic is_xfer_cmd(input logic [1:0] hi2);
    return hi2 == 2'b10;
  endfunction

  // bits 7:5 of a command byte select a write
  function automatic logic is_write_cmd(input logic [2:0] hi3);
    return hi3 == 3'b101;
  endfunction

  function automatic logic [SXS_DW-1:0] next_sector(input logic [SXS_DW-1:0] cur);
    return cur + SXS_DW'(1);
  endfunction

endpackage

// File: rtl/sxs_ms_timer.sv
module sxs_ms_timer #(
  parameter int CYC_PER_MS = 1000,
  parameter int MS_W       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms_count,
  output logic            done
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;
  logic             ms_tick;

  assign ms_tick = run_q && (pre_q == '0);
  assign done    = ms_tick && (ms_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      pre_q <= PRE_TOP;
      ms_q  <= ms_count - MS_W'(1);
    end else if (run_q) begin
      if (ms_tick) begin
        if (ms_q == '0) begin
          run_q <= 1'b0;
        end else begin
          ms_q  <= ms_q - MS_W'(1);
          pre_q <= PRE_TOP;
        end
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end

  // R4
  tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));

endmodule

// File: rtl/sxs_drq_pacer.sv
module sxs_drq_pacer #(
  parameter int GAP = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic force_set,
  input  logic take,
  input  logic clear,
  output logic drq
);
  localparam int CW = $clog2(GAP + 1);
  localparam logic [CW-1:0] GAP_MAX  = CW'(GAP);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP - 1);

  logic [CW-1:0] since_q;
  logic          drq_q;
  logic          drq_n;
  logic          changed;

  always_comb begin
    drq_n = drq_q;
    if (clear || take) begin
      drq_n = 1'b0;
    end else if (force_set) begin
      drq_n = 1'b1;
    end else if (enable && !drq_q && (since_q >= GAP_LAST)) begin
      drq_n = 1'b1;
    end
  end

  assign changed = (drq_n != drq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q   <= 1'b0;
      since_q <= GAP_MAX;
    end else begin
      drq_q <= drq_n;
      if (changed) begin
        since_q <= '0;
      end else if (since_q < GAP_MAX) begin
        since_q <= since_q + CW'(1);
      end
    end
  end

  assign drq = drq_q;

  // R10
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take || clear) |=> !drq);

endmodule

// File: rtl/sxs_byte_idx.sv
module sxs_byte_idx #(
  parameter int N = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  output logic [$clog2(N)-1:0] idx,
  output logic                 last
);
  localparam int AW = $clog2(N);
  localparam logic [AW-1:0] IDX_END = AW'(N - 1);

  logic [AW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clr) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= (idx_q == IDX_END) ? '0 : idx_q + AW'(1);
    end
  end

  assign idx  = idx_q;
  assign last = (idx_q == IDX_END);

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !last) |=> idx == $past(idx) + AW'(1));

endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq
  import sxs_pkg::*;
#(
  parameter int CYC_PER_MS   = 1000,
  parameter int SETTLE_MS    = 30,
  parameter int LOAD_MS      = 1,
  parameter int SECTOR_BYTES = 512,
  parameter int DRQ_GAP      = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic [1:0]                      reg_addr,
  input  logic [7:0]                      reg_wdata,
  output logic [7:0]                      reg_rdata,
  input  logic                            drv_ready,
  input  logic                            drv_wprot,
  output logic                            sec_req,
  output logic [7:0]                      sec_num,
  input  logic                            sec_arrive,
  input  logic [7:0]                      disk_track,
  output logic [$clog2(SECTOR_BYTES)-1:0] buf_addr,
  output logic                            buf_we,
  output logic [7:0]                      buf_wdata,
  input  logic [7:0]                      buf_rdata,
  output logic                            busy,
  output logic                            drq,
  output logic                            irq,
  output logic                            err_rnf,
  output logic                            err_wprot
);
  localparam int MS_MAX = (SETTLE_MS > LOAD_MS) ? SETTLE_MS : LOAD_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int AW     = $clog2(SECTOR_BYTES);
  localparam int GW     = $clog2(DRQ_GAP + 1);

  sxs_state_t        state_q;
  logic [SXS_DW-1:0] cmd_q;
  logic [SXS_DW-1:0] trk_q;
  logic [SXS_DW-1:0] sec_q;
  logic [SXS_DW-1:0] data_q;
  logic              irq_q;
  logic              rnf_q;
  logic              wp_q;
  logic              req_q;

  // named internal events
  logic cmd_wr, trk_wr, sec_wr, dat_wr, dat_rd;
  logic cmd_start, start_fail;
  logic tmr_start, tmr_done;
  logic [MS_W-1:0] tmr_ms;
  logic settle_done, load_done, wp_abort, find_go;
  logic arr_hit, arr_miss;
  logic in_xfer, xfer_is_wr, xfer_multi;
  logic take, last_take, seq_next;
  logic run_end;
  logic idx_last;
  logic [AW-1:0] idx;

  assign cmd_wr = reg_wr && (reg_addr == ADR_CMD);
  assign trk_wr = reg_wr && (reg_addr == ADR_TRK);
  assign sec_wr = reg_wr && (reg_addr == ADR_SEC);
  assign dat_wr = reg_wr && (reg_addr == ADR_DAT);
  assign dat_rd = reg_rd && (reg_addr == ADR_DAT);

  assign cmd_start  = cmd_wr && is_xfer_cmd(reg_wdata[7:6]);
  assign start_fail = cmd_start && !drv_ready;

  assign xfer_is_wr = is_write_cmd(cmd_q[7:5]);
  assign xfer_multi = cmd_q[4];

  assign settle_done = (state_q == ST_SETTLE) && tmr_done;
  assign load_done   = (state_q == ST_LOAD) && tmr_done;
  assign wp_abort    = load_done && xfer_is_wr && drv_wprot;
  assign find_go     = load_done && !wp_abort;

  assign arr_hit  = (state_q == ST_FIND) && sec_arrive && (disk_track == trk_q);
  assign arr_miss = (state_q == ST_FIND) && sec_arrive && (disk_track != trk_q);

  assign in_xfer   = (state_q == ST_XFER);
  assign take      = in_xfer && (xfer_is_wr ? dat_wr : dat_rd);
  assign last_take = take && idx_last;
  assign seq_next  = last_take && !xfer_is_wr && xfer_multi;

  // a fresh command overrides whatever the running one was about to do
  assign run_end = !cmd_start && (wp_abort || arr_miss || (last_take && !seq_next));

  assign tmr_start = (cmd_start && drv_ready) || (settle_done && !cmd_start);
  assign tmr_ms    = (cmd_start && reg_wdata[2]) ? MS_W'(SETTLE_MS) : MS_W'(LOAD_MS);

  sxs_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .ms_count (tmr_ms),
    .done     (tmr_done)
  );

  sxs_byte_idx #(
    .N (SECTOR_BYTES)
  ) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (arr_hit || cmd_start),
    .adv   (take),
    .idx   (idx),
    .last  (idx_last)
  );

  sxs_drq_pacer #(
    .GAP (DRQ_GAP)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (in_xfer),
    .force_set (arr_hit && xfer_is_wr && !cmd_start),
    .take      (take),
    .clear     (run_end || cmd_start),
    .drq       (drq)
  );

  // sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (cmd_start) begin
      if (!drv_ready)         state_q <= ST_IDLE;
      else if (reg_wdata[2])  state_q <= ST_SETTLE;
      else                    state_q <= ST_LOAD;
    end else begin
      case (state_q)
        ST_SETTLE: if (tmr_done) state_q <= ST_LOAD;
        ST_LOAD:   if (tmr_done) state_q <= wp_abort ? ST_IDLE : ST_FIND;
        ST_FIND:   if (sec_arrive) state_q <= arr_hit ? ST_XFER : ST_IDLE;
        ST_XFER:   if (last_take) state_q <= seq_next ? ST_FIND : ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // command, completion and error flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      irq_q <= 1'b0;
      rnf_q <= 1'b0;
      wp_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= !cmd_start && (find_go || seq_next);
      if (cmd_start) begin
        cmd_q <= reg_wdata;
        irq_q <= !drv_ready;
        rnf_q <= 1'b0;
        wp_q  <= 1'b0;
      end else begin
        if (run_end)        irq_q <= 1'b1;
        else if (cmd_wr)    irq_q <= 1'b0;
        if (arr_miss)       rnf_q <= 1'b1;
        if (wp_abort)       wp_q  <= 1'b1;
      end
    end
  end

  // host-visible registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q  <= '0;
      sec_q  <= SXS_DW'(1);
      data_q <= '0;
    end else begin
      if (trk_wr) trk_q <= reg_wdata;
      if (sec_wr)         sec_q <= reg_wdata;
      else if (seq_next)  sec_q <= next_sector(sec_q);
      if (dat_wr)                                data_q <= reg_wdata;
      else if (dat_rd && in_xfer && !xfer_is_wr) data_q <= buf_rdata;
    end
  end

  always_comb begin
    case (reg_addr)
      ADR_CMD: reg_rdata = cmd_q;
      ADR_TRK: reg_rdata = trk_q;
      ADR_SEC: reg_rdata = sec_q;
      default: reg_rdata = (in_xfer && !xfer_is_wr) ? buf_rdata : data_q;
    endcase
  end

  assign busy      = (state_q != ST_IDLE);
  assign irq       = irq_q;
  assign err_rnf   = rnf_q;
  assign err_wprot = wp_q;
  assign sec_req   = req_q;
  assign sec_num   = sec_q;
  assign buf_addr  = idx;
  assign buf_we    = take && xfer_is_wr;
  assign buf_wdata = reg_wdata;

  // checker-side spacing counter: cycles since drq last changed
  logic          drq_d;
  logic [GW-1:0] gap_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_d    <= 1'b0;
      gap_seen <= GW'(DRQ_GAP);
    end else begin
      drq_d <= drq;
      if (drq != drq_d)                 gap_seen <= '0;
      else if (gap_seen < GW'(DRQ_GAP)) gap_seen <= gap_seen + GW'(1);
    end
  end

  // R10
  drq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> busy);

  // R10
  drq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drq) |-> (gap_seen >= GW'(DRQ_GAP - 1)) || $past(sec_arrive));

  // R11
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq && !drq);

  // R7
  rnf_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_rnf) |-> !busy && irq);

  // R5
  wp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_wprot) |-> !busy && irq && !sec_req);

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req |=> !sec_req);

  // R12
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_req && $past(in_xfer) && !$past(sec_wr)) |-> sec_num == $past(sec_num) + SXS_DW'(1));

endmodule

// File: tb/sim_sector_xfer_seq.sv
module sim_sector_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM  = 10;
  localparam int SETL = 30;
  localparam int LDMS = 1;
  localparam int NB   = 512;
  localparam int GAP  = 15;
  localparam int AWB  = $clog2(NB);
  localparam int LOAD_CYC   = LDMS * CPM;
  localparam int SETTLE_CYC = SETL * CPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic drv_ready = 1'b1, drv_wprot = 1'b0;
  logic sec_req;
  logic [7:0] sec_num;
  logic sec_arrive = 1'b0;
  logic [7:0] disk_track = 8'd0;
  logic [AWB-1:0] buf_addr;
  logic buf_we;
  logic [7:0] buf_wdata, buf_rdata;
  logic busy, drq, irq, err_rnf, err_wprot;

  logic [7:0] rmem [NB];
  logic [7:0] wmem [NB];

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign buf_rdata = rmem[buf_addr];
  always @(posedge clk) if (buf_we) wmem[buf_addr] <= buf_wdata;

  sector_xfer_seq #(
    .CYC_PER_MS(CPM), .SETTLE_MS(SETL), .LOAD_MS(LDMS),
    .SECTOR_BYTES(NB), .DRQ_GAP(GAP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .drv_ready(drv_ready), .drv_wprot(drv_wprot),
    .sec_req(sec_req), .sec_num(sec_num), .sec_arrive(sec_arrive),
    .disk_track(disk_track), .buf_addr(buf_addr), .buf_we(buf_we),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .busy(busy), .drq(drq), .irq(irq), .err_rnf(err_rnf), .err_wprot(err_wprot)
  );

  function automatic logic [7:0] rpat(input int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  function automatic logic [7:0] wpat(input int i);
    return 8'((i * 13 + 5) ^ (i >> 7));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_req(output int cnt);
    cnt = 0;
    while (!sec_req) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic serve(input logic [7:0] trk);
    int c;
    wait_req(c);
    repeat (3) @(negedge clk);
    sec_arrive = 1'b1; disk_track = trk;
    @(negedge clk);
    sec_arrive = 1'b0;
  endtask

  task automatic read_sector(output int bad, output int gap0, output int drop0);
    bad = 0; gap0 = -1; drop0 = -1;
    for (int i = 0; i < NB; i++) begin
      while (!drq) @(negedge clk);
      reg_rd = 1'b1; reg_addr = 2'd3;
      #1 if (reg_rdata !== rpat(i)) bad++;
      @(negedge clk);
      reg_rd = 1'b0;
      if (i == 0) begin
        drop0 = int'(drq);
        gap0 = 0;
        while (!drq) begin
          @(negedge clk);
          gap0++;
        end
      end
    end
  endtask

  task automatic write_sector();
    for (int i = 0; i < NB; i++) begin
      while (!drq) @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = wpat(i);
      @(negedge clk);
      reg_wr = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 busy", int'(busy), 0);
    chk("R1 drq", int'(drq), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 flags", int'({err_rnf, err_wprot}), 0);
    host_rd(2'd1, v); chk("R1 track reg", int'(v), 0);
    host_rd(2'd2, v); chk("R1 sector reg", int'(v), 1);
  endtask

  task automatic t_ignored();
    host_wr(2'd0, 8'h10);
    chk("R2 other code keeps busy low", int'(busy), 0);
    chk("R2 other code irq", int'(irq), 0);
  endtask

  task automatic t_not_ready();
    drv_ready = 1'b0;
    host_wr(2'd0, 8'h80);
    chk("R3 not ready busy", int'(busy), 0);
    chk("R3 not ready irq", int'(irq), 1);
    drv_ready = 1'b1;
  endtask

  task automatic t_single_read();
    int c, bad, gap0, drop0;
    host_wr(2'd1, 8'd7);
    host_wr(2'd2, 8'd5);
    host_wr(2'd0, 8'h80);
    chk("R2 start busy", int'(busy), 1);
    chk("R2 start clears irq", int'(irq), 0);
    wait_req(c);
    chk("R4 load delay", c, LOAD_CYC);
    chk("R6 sec_num", int'(sec_num), 5);
    @(negedge clk);
    chk("R6 one-cycle pulse", int'(sec_req), 0);
    repeat (2) @(negedge clk);
    sec_arrive = 1'b1; disk_track = 8'd7;
    @(negedge clk);
    sec_arrive = 1'b0;
    read_sector(bad, gap0, drop0);
    chk("R9 read byte order", bad, 0);
    chk("R10 drq drop", drop0, 0);
    chk("R10 drq spacing", gap0, GAP);
    chk("R11 read end busy", int'(busy), 0);
    chk("R11 read end irq", int'(irq), 1);
    chk("R11 read end drq", int'(drq), 0);
  endtask

  task automatic t_settle_miss();
    int c;
    host_wr(2'd0, 8'h84);
    wait_req(c);
    chk("R4 settle+load delay", c, SETTLE_CYC + LOAD_CYC);
    serve(8'd3);
    chk("R7 rnf flag", int'(err_rnf), 1);
    chk("R7 busy", int'(busy), 0);
    chk("R7 irq", int'(irq), 1);
    chk("R7 drq", int'(drq), 0);
  endtask

  task automatic t_wprot();
    int c;
    drv_wprot = 1'b1;
    host_wr(2'd0, 8'hA0);
    chk("R2 start clears rnf", int'(err_rnf), 0);
    repeat (LOAD_CYC - 1) @(negedge clk);
    chk("R5 still busy", int'(busy), 1);
    @(negedge clk);
    chk("R5 wp flag", int'(err_wprot), 1);
    chk("R5 busy", int'(busy), 0);
    chk("R5 irq", int'(irq), 1);
    chk("R5 no request", int'(sec_req), 0);
    host_wr(2'd0, 8'h80);
    wait_req(c);
    chk("R5 read ignores protect", c, LOAD_CYC);
    serve(8'd0);
    chk("R7 rnf after protected read", int'(err_rnf), 1);
    drv_wprot = 1'b0;
  endtask

  task automatic t_write(input logic [7:0] cmd, input string tag);
    int bad;
    host_wr(2'd0, cmd);
    serve(8'd7);
    chk({tag, " R8 drq at arrival"}, int'(drq), 1);
    write_sector();
    bad = 0;
    for (int i = 0; i < NB; i++) if (wmem[i] !== wpat(i)) bad++;
    chk({tag, " R8 buffer contents"}, bad, 0);
    chk({tag, " R11 busy"}, int'(busy), 0);
    chk({tag, " R11 irq"}, int'(irq), 1);
    chk({tag, " R11 drq"}, int'(drq), 0);
  endtask

  task automatic t_multi_read();
    int c, bad, gap0, drop0;
    logic [7:0] v;
    host_wr(2'd2, 8'd9);
    host_wr(2'd0, 8'h90);
    wait_req(c);
    chk("R12 first sector", int'(sec_num), 9);
    serve(8'd7);
    read_sector(bad, gap0, drop0);
    chk("R12 first sector bytes", bad, 0);
    wait_req(c);
    chk("R12 immediate follow-on request", c, 0);
    chk("R12 next sector number", int'(sec_num), 10);
    chk("R12 busy held", int'(busy), 1);
    serve(8'd1);
    host_rd(2'd2, v);
    chk("R12 sector register", int'(v), 10);
    chk("R7 rnf ends multi read", int'(err_rnf), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) begin
      rmem[i] = rpat(i);
      wmem[i] = 8'h00;
    end
    @(negedge clk);
    t_reset();
    t_ignored();
    t_not_ready();
    t_single_read();
    t_settle_miss();
    t_wprot();
    host_wr(2'd1, 8'd7);
    t_write(8'hA0, "single");
    for (int i = 0; i < NB; i++) wmem[i] = 8'h00;
    t_write(8'hB0, "multi");
    t_multi_read();
    summary();
  end

endmodule